// File: doc/BRIEF.md
# Dual-Edge ADC Sample Packer

This block takes a 14-bit converter word and its over-range flag on both edges of the converter's data-ready clock. Each edge gives one 16-bit sample. Two consecutive samples are merged into one 32-bit word: the sample from a rising edge and the sample from the falling edge that follows it. The merged word is offered to the write side of a clock-crossing FIFO, one word per rising edge.

A controller starts a run by raising the enable and giving a sample target. The block counts the samples it has taken. It ends the run in one of two ways. The first is normal completion, when the count reaches the target. The second is a forced stop requested by the controller. Each ending gives a one-cycle done pulse, and a reason bit marks the forced case. A word that arrives while the FIFO reports full is dropped, and a sticky flag records the drop. After a run ends, the enable must go low before the next run can start.

Top module: `adc_ddr_packer`

## Requirements
- R1: Each sample is 16 bits wide. Bit 15 is always 0, bits 14:1 carry `adc_data[13:0]`, and bit 0 carries `adc_ovr`.
- R2: In a FIFO word, bits 15:0 hold the sample taken on a rising edge. Bits 31:16 hold the sample taken on the falling edge right after it.
- R3: A run starts on the first rising edge where `cap_en` is high and no run is active or finished. That edge clears the count and the overflow flag. The next rising edge takes the first sample of the first word, and that word is written on the third rising edge of the run.
- R4: `cap_count` goes up by exactly 2 for every word formed, whether or not the word is written. It stays even, and it holds its value after the run ends.
- R5: The run completes on the word that brings the count to at least the target, with bit 0 of the target ignored. That word is still written. In the same cycle, `cap_done` pulses for one cycle with `cap_done_forced` at 0. A target of 0 completes on the first word.
- R6: When `cap_stop` is high during a run, the run ends on that edge. No word is written in that cycle, and `cap_done` pulses together with `cap_done_forced` at 1. While no run is active, `cap_stop` has no effect.
- R7: A word is never written while `fifo_full` is high. The word is dropped and `cap_overflow` is set. The flag stays set until the next run starts.
- R8: If `cap_en` falls during a run, the run is abandoned on that edge. No further words are written and no done pulse is given.
- R9: After a run ends, no new run starts until `cap_en` has been low on at least one rising edge.
- R10: Synchronous reset clears the write strobe, the write data, the count, both done outputs and the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter data-ready clock; samples are taken on both edges |
| rst | input | 1 | Synchronous active-high reset |
| adc_data | input | 14 | Converter data word |
| adc_ovr | input | 1 | Converter over-range flag |
| cap_en | input | 1 | Run enable from the controller |
| cap_stop | input | 1 | Forced stop request |
| cap_target | input | 25 | Number of samples to take (even, at most 2^24) |
| fifo_full | input | 1 | Full indication from the FIFO write side |
| fifo_wr_en | output | 1 | FIFO write strobe |
| fifo_wr_data | output | 32 | Packed pair of samples |
| cap_count | output | 25 | Number of samples taken in the current or last run |
| cap_done | output | 1 | One-cycle pulse when a run ends |
| cap_done_forced | output | 1 | Set along with `cap_done` when the run ended by a forced stop |
| cap_overflow | output | 1 | Sticky flag set when a word was dropped because the FIFO was full |

## Verification
The hardest situations to produce from the ports are the ones where the run ends on a given edge relative to the pairing phase. Examples are a stop that lands right after a rising-edge sample was taken but before its word formed, and an enable that falls in the middle of a run. The stimulus counts rising edges from the start of the run and places `cap_stop` or the fall of `cap_en` at an exact edge number. Meanwhile, the converter inputs change every half cycle from a counting pattern, so every word shows which two half cycles it came from.

// File: rtl/adc_pack_pkg.sv
package adc_pack_pkg;

  parameter int unsigned ADC_BITS  = 14;
  parameter int unsigned SMP_BITS  = ADC_BITS + 2;
  parameter int unsigned PAIR_BITS = 2 * SMP_BITS;

  typedef logic [SMP_BITS-1:0]  smp_t;
  typedef logic [PAIR_BITS-1:0] pair_t;

  // Pad bit on top, converter word in the middle, over-range flag at the bottom.
  function automatic smp_t form_sample(input logic [ADC_BITS-1:0] word,
                                       input logic ovr);
    return {1'b0, word, ovr};
  endfunction

endpackage

// File: rtl/adc_edge_regs.sv
module adc_edge_regs
  import adc_pack_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [ADC_BITS-1:0] adc_data,
  input  logic                adc_ovr,
  output smp_t                rise_smp,
  output smp_t                fall_smp
);

  smp_t now_smp;
  assign now_smp = form_sample(adc_data, adc_ovr);

  always_ff @(posedge clk) begin
    if (rst) rise_smp <= '0;
    else     rise_smp <= now_smp;
  end

  always_ff @(negedge clk) begin
    if (rst) fall_smp <= '0;
    else     fall_smp <= now_smp;
  end

endmodule

// File: rtl/adc_run_ctrl.sv
module adc_run_ctrl #(
  parameter int unsigned CNT_W = 25
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             stop,
  input  logic [CNT_W-1:0] target,
  output logic             start,
  output logic             emit,
  output logic [CNT_W-1:0] count,
  output logic             done,
  output logic             done_forced
);

  localparam logic [CNT_W:0] STEP = (CNT_W+1)'(2);

  logic             active;
  logic             phase;
  logic             spent;
  logic [CNT_W-1:0] goal;
  logic [CNT_W:0]   next_cnt;
  logic             reached;

  assign start    = en && !active && !spent;
  assign emit     = en && active && !stop && phase;
  assign next_cnt = {1'b0, count} + STEP;
  assign reached  = next_cnt >= {1'b0, goal};

  always_ff @(posedge clk) begin
    if (rst) begin
      active      <= 1'b0;
      phase       <= 1'b0;
      spent       <= 1'b0;
      goal        <= '0;
      count       <= '0;
      done        <= 1'b0;
      done_forced <= 1'b0;
    end else begin
      done        <= 1'b0;
      done_forced <= 1'b0;
      if (!en) begin
        active <= 1'b0;
        phase  <= 1'b0;
        spent  <= 1'b0;
      end else if (start) begin
        active <= 1'b1;
        phase  <= 1'b0;
        count  <= '0;
        goal   <= target & ~CNT_W'(1);
      end else if (active) begin
        if (stop) begin
          active      <= 1'b0;
          phase       <= 1'b0;
          spent       <= 1'b1;
          done        <= 1'b1;
          done_forced <= 1'b1;
        end else if (phase) begin
          count <= next_cnt[CNT_W-1:0];
          if (reached) begin
            active <= 1'b0;
            phase  <= 1'b0;
            spent  <= 1'b1;
            done   <= 1'b1;
          end
        end else begin
          phase <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/adc_pair_packer.sv
module adc_pair_packer
  import adc_pack_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  start,
  input  logic  emit,
  input  logic  full,
  input  smp_t  rise_smp,
  input  smp_t  fall_smp,
  output logic  wr_en,
  output pair_t wr_data,
  output logic  overflow
);

  smp_t  lane [2];
  pair_t word;

  assign lane[0] = rise_smp;
  assign lane[1] = fall_smp;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign word[g*SMP_BITS +: SMP_BITS] = lane[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en    <= 1'b0;
      wr_data  <= '0;
      overflow <= 1'b0;
    end else begin
      wr_en <= emit && !full;
      if (emit) wr_data <= word;
      if (start)             overflow <= 1'b0;
      else if (emit && full) overflow <= 1'b1;
    end
  end

endmodule

// File: rtl/adc_ddr_packer.sv
module adc_ddr_packer
  import adc_pack_pkg::*;
#(
  parameter int unsigned CNT_W = 25
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADC_BITS-1:0]  adc_data,
  input  logic                 adc_ovr,
  input  logic                 cap_en,
  input  logic                 cap_stop,
  input  logic [CNT_W-1:0]     cap_target,
  input  logic                 fifo_full,
  output logic                 fifo_wr_en,
  output logic [PAIR_BITS-1:0] fifo_wr_data,
  output logic [CNT_W-1:0]     cap_count,
  output logic                 cap_done,
  output logic                 cap_done_forced,
  output logic                 cap_overflow
);

  smp_t rise_smp;
  smp_t fall_smp;
  logic start;
  logic emit;

  adc_edge_regs u_edges (
    .clk      (clk),
    .rst      (rst),
    .adc_data (adc_data),
    .adc_ovr  (adc_ovr),
    .rise_smp (rise_smp),
    .fall_smp (fall_smp)
  );

  adc_run_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .en          (cap_en),
    .stop        (cap_stop),
    .target      (cap_target),
    .start       (start),
    .emit        (emit),
    .count       (cap_count),
    .done        (cap_done),
    .done_forced (cap_done_forced)
  );

  adc_pair_packer u_pack (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .emit     (emit),
    .full     (fifo_full),
    .rise_smp (rise_smp),
    .fall_smp (fall_smp),
    .wr_en    (fifo_wr_en),
    .wr_data  (fifo_wr_data),
    .overflow (cap_overflow)
  );

endmodule

// File: rtl/adc_ddr_packer_chk.sv
module adc_ddr_packer_chk #(
  parameter int unsigned CNT_W = 25
) (
  input logic             clk,
  input logic             rst,
  input logic             cap_en,
  input logic             fifo_full,
  input logic             fifo_wr_en,
  input logic [31:0]      fifo_wr_data,
  input logic [CNT_W-1:0] cap_count,
  input logic             cap_done,
  input logic             cap_done_forced,
  input logic             cap_overflow
);

  p_pad_zero_r1: assert property (@(posedge clk) disable iff (rst)
    fifo_wr_en |-> (!fifo_wr_data[15] && !fifo_wr_data[31]));

  p_count_even_r4: assert property (@(posedge clk) disable iff (rst)
    !cap_count[0]);

  p_count_step_r4: assert property (@(posedge clk) disable iff (rst)
    (cap_count != $past(cap_count)) |->
      (cap_count == CNT_W'($past(cap_count) + CNT_W'(2)) || cap_count == '0));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    cap_done |=> !cap_done);

  p_forced_with_done_r6: assert property (@(posedge clk) disable iff (rst)
    cap_done_forced |-> cap_done);

  p_no_write_full_r7: assert property (@(posedge clk) disable iff (rst)
    fifo_wr_en |-> !$past(fifo_full));

  p_overflow_cause_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(cap_overflow) |-> $past(fifo_full));

  p_write_needs_en_r8: assert property (@(posedge clk) disable iff (rst)
    fifo_wr_en |-> $past(cap_en));

endmodule

bind adc_ddr_packer adc_ddr_packer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .cap_en          (cap_en),
  .fifo_full       (fifo_full),
  .fifo_wr_en      (fifo_wr_en),
  .fifo_wr_data    (fifo_wr_data),
  .cap_count       (cap_count),
  .cap_done        (cap_done),
  .cap_done_forced (cap_done_forced),
  .cap_overflow    (cap_overflow)
);

// File: tb/adc_ddr_packer_tb.sv
module adc_ddr_packer_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic [13:0] adc_data;
  logic        adc_ovr;
  logic        cap_en;
  logic        cap_stop;
  logic [24:0] cap_target;
  logic        fifo_full;
  logic        fifo_wr_en;
  logic [31:0] fifo_wr_data;
  logic [24:0] cap_count;
  logic        cap_done;
  logic        cap_done_forced;
  logic        cap_overflow;

  int n_chk  = 0;
  int n_fail = 0;
  int hidx   = 0;

  always #4 clk = ~clk;

  adc_ddr_packer u_dut (
    .clk             (clk),
    .rst             (rst),
    .adc_data        (adc_data),
    .adc_ovr         (adc_ovr),
    .cap_en          (cap_en),
    .cap_stop        (cap_stop),
    .cap_target      (cap_target),
    .fifo_full       (fifo_full),
    .fifo_wr_en      (fifo_wr_en),
    .fifo_wr_data    (fifo_wr_data),
    .cap_count       (cap_count),
    .cap_done        (cap_done),
    .cap_done_forced (cap_done_forced),
    .cap_overflow    (cap_overflow)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Converter inputs change 1 ns after every clock edge.
  initial begin
    adc_data = '0;
    adc_ovr  = 1'b0;
    forever begin
      @(posedge clk or negedge clk);
      #1;
      hidx++;
      adc_data = 14'(hidx * 1237 + 55);
      adc_ovr  = ((hidx % 3) == 1);
    end
  end

  // Bench record of what sat on the inputs at each edge.
  logic [15:0] pos_q = '0, pos_prev = '0, neg_q = '0;
  always @(posedge clk) begin
    pos_prev <= pos_q;
    pos_q    <= {1'b0, adc_data, adc_ovr};
  end
  always @(negedge clk) neg_q <= {1'b0, adc_data, adc_ovr};

  // R1/R2: every written word is {fall sample, preceding rise sample}.
  always @(posedge clk) begin
    #2;
    if (!rst && fifo_wr_en)
      check("R1/R2 packed word", 64'(fifo_wr_data), 64'({neg_q, pos_prev}));
  end

  // target, stop edge (0 = none), full, writes, forced, overflow, final count
  localparam int NV = 7;
  localparam int VEC [NV][7] = '{
    '{ 8, 0, 0, 4, 0, 0,  8},
    '{ 2, 0, 0, 1, 0, 0,  2},
    '{ 7, 0, 0, 3, 0, 0,  6},
    '{ 0, 0, 0, 1, 0, 0,  2},
    '{40, 6, 0, 4, 1, 0,  8},
    '{10, 0, 1, 0, 0, 1, 10},
    '{30, 2, 0, 0, 1, 0,  0}
  };

  task automatic run_capture(input int tgt, input int stop_at, input int full,
                             input int exp_w, input int exp_f, input int exp_o,
                             input int exp_cnt);
    int  w = 0;
    int  first = -1;
    bit  d = 0;
    bit  f = 0;
    bit  last_wr = 0;
    for (int c = 0; c < 200 && !d; c++) begin
      @(negedge clk);
      cap_en     = 1'b1;
      cap_target = 25'(tgt);
      fifo_full  = full[0];
      cap_stop   = (stop_at != 0 && c == stop_at);
      @(posedge clk);
      #2;
      if (fifo_wr_en) begin
        w++;
        if (first < 0) first = c;
      end
      if (cap_done) begin
        d = 1;
        f = cap_done_forced;
        last_wr = fifo_wr_en;
      end
    end
    check("R5/R6 done pulse seen", 64'(d), 64'd1);
    check("R5/R6 done reason", 64'(f), 64'(exp_f));
    check("R4/R7 write count", 64'(w), 64'(exp_w));
    check("R7 overflow flag", 64'(cap_overflow), 64'(exp_o));
    check("R4 final count", 64'(cap_count), 64'(exp_cnt));
    if (exp_w > 0) check("R3 first write edge", 64'(first), 64'd2);
    if (exp_f == 0 && exp_w > 0) check("R5 last word written with done", 64'(last_wr), 64'd1);
    @(posedge clk);
    #2;
    check("R5 done one cycle", 64'(cap_done), 64'd0);
    @(negedge clk);
    cap_en    = 1'b0;
    cap_stop  = 1'b0;
    fifo_full = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst        = 1'b1;
    cap_en     = 1'b0;
    cap_stop   = 1'b0;
    cap_target = '0;
    fifo_full  = 1'b0;
    repeat (4) @(posedge clk);
    #2;
    // R10: reset state
    check("R10 wr_en", 64'(fifo_wr_en), 64'd0);
    check("R10 wr_data", 64'(fifo_wr_data), 64'd0);
    check("R10 count", 64'(cap_count), 64'd0);
    check("R10 done", 64'({cap_done, cap_done_forced}), 64'd0);
    check("R10 overflow", 64'(cap_overflow), 64'd0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++)
      run_capture(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], VEC[i][5], VEC[i][6]);

    // R9: enable held high after completion starts nothing new.
    begin
      int extra = 0;
      for (int c = 0; c < 20; c++) begin
        @(negedge clk);
        cap_en = 1'b1;
        cap_target = 25'd4;
        @(posedge clk);
        #2;
        if (c > 4 && (fifo_wr_en || cap_done)) extra++;
      end
      check("R9 no restart while enable stays high", 64'(extra), 64'd0);
      check("R9 count held", 64'(cap_count), 64'd4);
      @(negedge clk);
      cap_en = 1'b0;
      @(negedge clk);
    end

    // R8: enable dropped mid-run abandons it silently.
    begin
      int w = 0;
      int late = 0;
      for (int c = 0; c < 5; c++) begin
        @(negedge clk);
        cap_en = 1'b1;
        cap_target = 25'd100;
        @(posedge clk);
        #2;
        if (fifo_wr_en) w++;
      end
      check("R8 writes before drop", 64'(w), 64'd3);
      for (int c = 0; c < 10; c++) begin
        @(negedge clk);
        cap_en = 1'b0;
        @(posedge clk);
        #2;
        if (fifo_wr_en || cap_done) late++;
      end
      check("R8 no write or done after drop", 64'(late), 64'd0);
      check("R8 count held", 64'(cap_count), 64'd6);
    end

    // R6: stop while idle has no effect.
    begin
      int hits = 0;
      for (int c = 0; c < 6; c++) begin
        @(negedge clk);
        cap_stop = 1'b1;
        @(posedge clk);
        #2;
        if (cap_done || cap_done_forced || fifo_wr_en) hits++;
      end
      check("R6 stop ignored when idle", 64'(hits), 64'd0);
      check("R6 idle count unchanged", 64'(cap_count), 64'd6);
      @(negedge clk);
      cap_stop = 1'b0;
    end

    // R3: a fresh run clears the count left by the abandoned one.
    run_capture(12, 0, 0, 6, 0, 0, 12);

    summary();
    $finish;
  end

endmodule